// File: doc/BRIEF.md
# Power Event Script Sequencer

This block plays back short power-management programs that are kept in a small script memory. Each program is a chain of 32-bit instructions. An instruction holds a 16-bit power bus message, a delay byte and the index of the instruction that follows it. Four kinds of event can start a program: warm reset, entry to sleep, wakeup of processor groups P1/P2, and wakeup of group P3. Each kind has its own start-index input. The block latches incoming requests and picks one by fixed priority. It then fetches each instruction from the memory, emits the message as a one-cycle strobe, counts out the delay and follows the chain until it reaches the terminator index.

Processor groups use one-hot vectors: bit 0 is P1 (0x1), bit 1 is P2 (0x2), bit 2 is P3 (0x4), and zero means no group. A wakeup request counts only for groups whose wake enable bit is set. A warm-reset request counts only for groups whose warm enable bit is set. Turning the messages into regulator actions belongs to a separate block.

Top module: `pm_script_seq`

## Requirements
- R1: After reset, busy, the message strobe and the memory read strobe are all low, and no read or strobe occurs until an event is requested.
- R2: Instruction index i is read at byte address 4×i. The word holds the message in bits [31:16], the delay in bits [15:8] and the next index in bits [7:0]. Execution follows the next index from one instruction to the next, and a next index of 0x3f ends the program after the instruction that carries it. Index 0x3f is never fetched.
- R3: The message emitted equals bits [31:16] of the fetched word, and the messages of a program appear in chain order.
- R4: When an instruction with delay d is strobed in cycle c, the next instruction of the same program is strobed in cycle c+d+3. A delay of 0 starts the next fetch in the cycle right after the strobe.
- R5: The message strobe is high for exactly one cycle per instruction, and never in the same cycle as a memory read.
- R6: Busy rises in the same cycle as the first memory read of a program. After the final instruction, strobed with delay d in cycle c, busy is low from cycle c+d+1.
- R7: Each event kind starts at its own start index. Warm reset uses the warm input, sleep uses the active-to-sleep input, a P1 or P2 wakeup uses the P1/P2 input, and a P3 wakeup uses the P3 input.
- R8: A wakeup request for a group whose wake enable bit is clear is discarded. Setting the enable bit later does not start a program.
- R9: A warm-reset request for a group whose warm enable bit is clear is discarded.
- R10: When several event kinds are pending together, they run one after another in the order warm reset, sleep, P1/P2 wakeup, P3 wakeup.
- R11: An event that arrives while a program is running is held and runs after the current program ends.
- R12: An event whose start index is 0x3f is consumed without any read, strobe or busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req_i | input | 1 | Request to run the active-to-sleep program |
| wake_req_i | input | 3 | Per-group wakeup request (bit0 P1, bit1 P2, bit2 P3) |
| wrst_req_i | input | 3 | Per-group warm-reset request |
| wake_en_i | input | 3 | Per-group wake enable |
| wrst_en_i | input | 3 | Per-group warm-reset enable |
| a2s_start_i | input | IDX_W | Start index of the sleep program |
| s2a12_start_i | input | IDX_W | Start index of the P1/P2 wakeup program |
| s2a3_start_i | input | IDX_W | Start index of the P3 wakeup program |
| warm_start_i | input | IDX_W | Start index of the warm-reset program |
| mem_rd_o | output | 1 | Script memory read strobe |
| mem_addr_o | output | IDX_W+2 | Byte address of the instruction being read |
| mem_rdata_i | input | 32 | Instruction word, valid one cycle after the read strobe |
| msg_vld_o | output | 1 | One-cycle message strobe |
| msg_o | output | 16 | Power bus message |
| busy_o | output | 1 | A program is being executed |

## Verification
The assertions assume that the script memory returns a word one cycle after each read strobe. They also assume that every chain ends at 0x3f and holds no next index above it, so a read of the terminator index never happens. The bench loads all programs before it raises any event, gives every next byte a value below or equal to 0x3f, and keeps chains free of loops. Request pulses last one cycle, so a request never coincides with the acceptance of the same kind.

// File: rtl/pm_seq_pkg.sv
// Shared types for the power event script sequencer.
// Assumes a 32-bit instruction word with message on top, then delay, then next index.
package pm_seq_pkg;

    localparam int MSG_W = 16;
    localparam int DLY_W = 8;
    localparam int PTR_W = 8;
    localparam int NGRP  = 3;
    localparam int NKIND = 4;

    // Event kinds, listed in falling priority
    typedef enum logic [1:0] {
        EV_WARM   = 2'd0,
        EV_SLEEP  = 2'd1,
        EV_WAKE12 = 2'd2,
        EV_WAKE3  = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE,
        ST_HOLD
    } seq_st_e;

    typedef struct packed {
        logic [MSG_W-1:0] msg;
        logic [DLY_W-1:0] dly;
        logic [PTR_W-1:0] nxt;
    } ins_t;

    localparam int INS_W = $bits(ins_t);

endpackage

// File: rtl/pm_evt_arb.sv
// Event latch and fixed-priority arbiter.
// Gates wakeup and warm-reset requests with the per-group enables, holds one
// pending flag per event kind and offers the highest-priority one.
// Assumes take is raised only while grant_vld is high.
module pm_evt_arb
    import pm_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic [NGRP-1:0] wake_req,
    input  logic [NGRP-1:0] wrst_req,
    input  logic [NGRP-1:0] wake_en,
    input  logic [NGRP-1:0] wrst_en,
    input  logic            take,
    output logic            grant_vld,
    output ev_kind_e        grant_kind
);

    logic [NKIND-1:0] pend_q;
    logic [NKIND-1:0] set_v;
    logic [NKIND-1:0] clr_v;

    // Qualify incoming requests by kind
    always_comb begin
        set_v            = '0;
        set_v[EV_WARM]   = |(wrst_req & wrst_en);
        set_v[EV_SLEEP]  = sleep_req;
        set_v[EV_WAKE12] = |(wake_req[1:0] & wake_en[1:0]);
        set_v[EV_WAKE3]  = wake_req[2] & wake_en[2];
    end

    // Pick the lowest-numbered pending kind
    always_comb begin
        grant_vld  = 1'b0;
        grant_kind = EV_WARM;
        for (int k = NKIND - 1; k >= 0; k--) begin
            if (pend_q[k]) begin
                grant_vld  = 1'b1;
                grant_kind = ev_kind_e'(k);
            end
        end
    end

    // Clear mask for the accepted kind
    always_comb begin
        clr_v = '0;
        if (take) clr_v[grant_kind] = 1'b1;
    end

    // Pending flags: cleared on acceptance, set by new requests
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_v) | set_v;
    end

endmodule

// File: rtl/pm_dly_timer.sv
// Delay down-counter for the gap after each message.
// Loads the delay byte when a message is issued and counts down while enabled.
// Assumes load and dec are never high together.
module pm_dly_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    // Expiry flag
    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pm_script_seq.sv
// Power event script sequencer top.
// Fetches linked instructions from a synchronous script memory (one-cycle read
// latency), strobes each message, waits its delay and follows the next index
// until the terminator (all-ones index). Start index per event kind.
// Assumes IDX_W <= 8 and that every chain ends at the terminator.
module pm_script_seq
    import pm_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req_i,
    input  logic [NGRP-1:0]   wake_req_i,
    input  logic [NGRP-1:0]   wrst_req_i,
    input  logic [NGRP-1:0]   wake_en_i,
    input  logic [NGRP-1:0]   wrst_en_i,
    input  logic [IDX_W-1:0]  a2s_start_i,
    input  logic [IDX_W-1:0]  s2a12_start_i,
    input  logic [IDX_W-1:0]  s2a3_start_i,
    input  logic [IDX_W-1:0]  warm_start_i,
    output logic              mem_rd_o,
    output logic [IDX_W+1:0]  mem_addr_o,
    input  logic [INS_W-1:0]  mem_rdata_i,
    output logic              msg_vld_o,
    output logic [MSG_W-1:0]  msg_o,
    output logic              busy_o
);

    localparam logic [PTR_W-1:0] TERM     = PTR_W'((2 ** IDX_W) - 1);
    localparam logic [IDX_W-1:0] TERM_IDX = TERM[IDX_W-1:0];

    seq_st_e          st_q;
    logic [IDX_W-1:0] idx_q;
    logic [PTR_W-1:0] nxt_q;
    logic [MSG_W-1:0] msg_q;
    logic             vld_q;
    logic             grant_vld;
    ev_kind_e         grant_kind;
    logic             take;
    logic [IDX_W-1:0] start_sel;
    logic             tmr_zero;
    ins_t             ins;

    assign ins  = ins_t'(mem_rdata_i);
    assign take = (st_q == ST_IDLE) && grant_vld;

    pm_evt_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req_i),
        .wake_req   (wake_req_i),
        .wrst_req   (wrst_req_i),
        .wake_en    (wake_en_i),
        .wrst_en    (wrst_en_i),
        .take       (take),
        .grant_vld  (grant_vld),
        .grant_kind (grant_kind)
    );

    pm_dly_timer #(.W(DLY_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_q == ST_ISSUE),
        .load_val (ins.dly),
        .dec      ((st_q == ST_HOLD) && !tmr_zero),
        .zero     (tmr_zero)
    );

    // Start index for the granted event kind
    always_comb begin
        case (grant_kind)
            EV_WARM:   start_sel = warm_start_i;
            EV_SLEEP:  start_sel = a2s_start_i;
            EV_WAKE12: start_sel = s2a12_start_i;
            default:   start_sel = s2a3_start_i;
        endcase
    end

    // Sequencer: idle -> fetch -> issue -> hold (delay) -> fetch or idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            nxt_q <= '0;
            msg_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (grant_vld && (start_sel != TERM_IDX)) begin
                        idx_q <= start_sel;
                        st_q  <= ST_FETCH;
                    end
                end
                ST_FETCH: st_q <= ST_ISSUE;
                ST_ISSUE: begin
                    msg_q <= ins.msg;
                    nxt_q <= ins.nxt;
                    vld_q <= 1'b1;
                    st_q  <= ST_HOLD;
                end
                default: begin
                    if (tmr_zero) begin
                        if (nxt_q == TERM) begin
                            st_q <= ST_IDLE;
                        end else begin
                            idx_q <= nxt_q[IDX_W-1:0];
                            st_q  <= ST_FETCH;
                        end
                    end
                end
            endcase
        end
    end

    assign mem_rd_o   = (st_q == ST_FETCH);
    assign mem_addr_o = {idx_q, 2'b00};
    assign msg_vld_o  = vld_q;
    assign msg_o      = msg_q;
    assign busy_o     = (st_q != ST_IDLE);

endmodule

// File: rtl/pm_script_seq_chk.sv
// Assertion checker for pm_script_seq, attached by bind.
// Assumes the script memory answers one cycle after each read strobe.
module pm_script_seq_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             msg_vld,
    input logic             mem_rd,
    input logic [IDX_W-1:0] mem_idx
);

    localparam logic [IDX_W-1:0] TERM_IDX = '1;

    a_r1_idle_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !msg_vld && !mem_rd));

    a_r2_no_terminator_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_idx != TERM_IDX));

    a_r4_fetch_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> ##1 msg_vld);

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        msg_vld |=> !msg_vld);

    a_r5_strobe_not_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        msg_vld |-> !mem_rd);

    a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    a_r6_busy_rises_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_rd);

    a_r6_strobe_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        msg_vld |-> busy);

endmodule

bind pm_script_seq pm_script_seq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_o),
    .msg_vld (msg_vld_o),
    .mem_rd  (mem_rd_o),
    .mem_idx (mem_addr_o[IDX_W+1:2])
);

// File: tb/pm_script_seq_bench.sv
`timescale 1ns/1ps
module pm_script_seq_bench;

    localparam int IDX_W = 6;
    localparam int TERM  = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_req = 1'b0;
    logic [2:0]  wake_req = '0, wrst_req = '0, wake_en = '0, wrst_en = '0;
    logic [5:0]  a2s_start = '0, s2a12_start = '0, s2a3_start = '0, warm_start = '0;
    logic        mem_rd;
    logic [7:0]  mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        msg_vld;
    logic [15:0] msg;
    logic        busy;

    logic [31:0] mem [0:63];
    int cyc = 0;
    int n_chk = 0, n_bad = 0;

    typedef struct {
        logic [15:0] msg;
        int          gap;
    } exp_t;
    exp_t q[$];

    int last_strobe = 0, strobe_cnt = 0, rise_cnt = 0;
    bit prev_vld = 0, prev_busy = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Script memory model: one-cycle read
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];

    pm_script_seq #(.IDX_W(IDX_W)) u_pm_script_seq (
        .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
        .wrst_req_i(wrst_req), .wake_en_i(wake_en), .wrst_en_i(wrst_en),
        .a2s_start_i(a2s_start), .s2a12_start_i(s2a12_start), .s2a3_start_i(s2a3_start),
        .warm_start_i(warm_start), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
        .mem_rdata_i(mem_rdata), .msg_vld_o(msg_vld), .msg_o(msg), .busy_o(busy)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares strobes against the scoreboard queue
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n) begin
            if (msg_vld) begin
                check(!prev_vld, "R5", "strobe longer than one cycle", 1, 0);
                if (q.size() == 0) begin
                    check(0, "R2", "unexpected strobe", int'(msg), 0);
                end else begin
                    e = q.pop_front();
                    check(msg == e.msg, "R3", "message", int'(msg), int'(e.msg));
                    if (e.gap != 0)
                        check(cyc - last_strobe == e.gap, "R4", "strobe spacing",
                              cyc - last_strobe, e.gap);
                end
                last_strobe = cyc;
                strobe_cnt++;
            end
            if (busy && !prev_busy) begin
                rise_cnt++;
                check(mem_rd, "R6", "busy rise without read", int'(mem_rd), 1);
            end
            prev_vld  = msg_vld;
            prev_busy = busy;
        end
    end

    task automatic put_ins(int i, logic [15:0] m, logic [7:0] d, logic [7:0] n);
        mem[i] = {m, d, n};
    endtask

    // Driver: walks the model memory and pushes expected strobes
    task automatic expect_script(int start);
        int i = start;
        int prev = -1;
        exp_t e;
        while (i != TERM) begin
            e.msg = mem[i][31:16];
            e.gap = (prev < 0) ? 0 : prev + 3;
            q.push_back(e);
            prev = int'(mem[i][15:8]);
            i = int'(mem[i][5:0]);
        end
    endtask

    task automatic pulse(logic sl, logic [2:0] wk, logic [2:0] wr);
        @(negedge clk);
        sleep_req = sl; wake_req = wk; wrst_req = wr;
        @(negedge clk);
        sleep_req = 1'b0; wake_req = '0; wrst_req = '0;
    endtask

    task automatic wait_quiet();
        int quiet = 0;
        while (quiet < 6) begin
            @(negedge clk); #1;
            if (busy) quiet = 0; else quiet++;
        end
    endtask

    task automatic idle_for(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : wdog
        #(4 * 50000);
        check(0, "R1", "watchdog expired", cyc, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int s, r;
        for (int i = 0; i < 64; i++) mem[i] = {16'hEEEE, 8'h00, 8'h3f};
        put_ins(2,  16'h1108, 8'd2, 8'd7);
        put_ins(7,  16'h2200, 8'd0, 8'd4);
        put_ins(4,  16'h33A5, 8'd5, 8'd63);
        put_ins(12, 16'h4A08, 8'd1, 8'd13);
        put_ins(13, 16'h4B00, 8'd3, 8'd63);
        put_ins(20, 16'h5C10, 8'd0, 8'd63);
        put_ins(30, 16'h6E08, 8'd4, 8'd31);
        put_ins(31, 16'h6F01, 8'd0, 8'd63);
        s2a12_start = 6'd2; a2s_start = 6'd12; warm_start = 6'd20; s2a3_start = 6'd30;

        idle_for(4);
        rst_n = 1'b1;
        idle_for(3); #1;
        // R1: reset state
        check(!busy, "R1", "busy after reset", int'(busy), 0);
        check(!msg_vld, "R1", "strobe after reset", int'(msg_vld), 0);
        check(!mem_rd, "R1", "read after reset", int'(mem_rd), 0);

        // R7 sleep program
        expect_script(12);
        pulse(1'b1, '0, '0);
        wait_quiet();
        check(q.size() == 0, "R7", "sleep program incomplete", q.size(), 0);

        // R2/R4/R6: chained wakeup program with non-sequential links
        wake_en = 3'b011;
        expect_script(2);
        pulse(1'b0, 3'b010, '0);
        while (q.size() != 0) begin @(negedge clk); #1; end
        while (busy) begin @(negedge clk); #1; end
        check(cyc - last_strobe == 6, "R6", "busy fall after last delay", cyc - last_strobe, 6);
        wait_quiet();
        check(q.size() == 0, "R2", "chain incomplete", q.size(), 0);

        // R8: P3 wakeup while disabled is discarded
        s = strobe_cnt; r = rise_cnt;
        pulse(1'b0, 3'b100, '0);
        idle_for(10);
        wake_en = 3'b111;
        idle_for(10);
        check(strobe_cnt == s, "R8", "strobes from disabled wakeup", strobe_cnt - s, 0);
        check(rise_cnt == r, "R8", "busy from disabled wakeup", rise_cnt - r, 0);

        // R7: P3 wakeup enabled
        expect_script(30);
        pulse(1'b0, 3'b100, '0);
        wait_quiet();
        check(q.size() == 0, "R7", "P3 wakeup program incomplete", q.size(), 0);

        // R9: warm reset with enable clear is discarded
        s = strobe_cnt;
        pulse(1'b0, '0, 3'b001);
        idle_for(12);
        check(strobe_cnt == s, "R9", "strobes from disabled warm reset", strobe_cnt - s, 0);
        wrst_en = 3'b001;
        expect_script(20);
        pulse(1'b0, '0, 3'b001);
        wait_quiet();
        check(q.size() == 0, "R7", "warm program incomplete", q.size(), 0);

        // R10: all kinds at once run by priority
        expect_script(20); expect_script(12); expect_script(2); expect_script(30);
        pulse(1'b1, 3'b101, 3'b001);
        wait_quiet();
        check(q.size() == 0, "R10", "priority run incomplete", q.size(), 0);

        // R11: request during a run is held
        expect_script(2); expect_script(12);
        pulse(1'b0, 3'b001, '0);
        idle_for(4);
        check(busy, "R11", "first program running", int'(busy), 1);
        pulse(1'b1, '0, '0);
        wait_quiet();
        check(q.size() == 0, "R11", "held event not run", q.size(), 0);

        // R12: start index at terminator consumes the event silently
        warm_start = 6'd63;
        s = strobe_cnt; r = rise_cnt;
        pulse(1'b0, '0, 3'b001);
        idle_for(12);
        check(rise_cnt == r, "R12", "busy for terminator start", rise_cnt - r, 0);
        check(strobe_cnt == s, "R12", "strobe for terminator start", strobe_cnt - s, 0);
        expect_script(12);
        pulse(1'b1, '0, '0);
        wait_quiet();
        check(q.size() == 0, "R12", "following event", q.size(), 0);
        check(rise_cnt == r + 1, "R12", "one program after discard", rise_cnt - r, 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule